// File: doc/BRIEF.md
# Output Clock Phase Realignment Controller

This block sits beside a post-divider chain and lets an external alignment strobe stop the divided output clock and then restart it with a known phase. It watches the strobe and the divided clock's present level, all in the fast clock domain. It drives two controls into the divider chain: a hold request that freezes the chain, and a one-cycle preload pulse that loads every stage counter to zero at the same moment. A half-cycle flag travels with the preload. It tells the divider whether the strobe edge arrived in the high or the low half of the fast clock period, so the restart can be placed with half-period resolution.

One strobe edge is the "stop" edge and the opposite edge is the "go" edge. A polarity bit chooses which is which, and an enable bit switches the whole feature off. A stop edge while the clock runs parks the output low. The hold is not raised until the divided clock is observed low, so the output never shows a shortened high pulse. A go edge while parked issues the preload and then drops the hold. The restart therefore follows the go edge by a fixed number of fast clock cycles.

The controller has four states. RUN: the divider runs freely. DRAIN: a stop edge came while the output was high, and the controller waits for the low level. PARKED: hold is asserted. LOAD: the single preload cycle. The transitions are: RUN to PARKED on a stop edge with the output low. RUN to DRAIN on a stop edge with the output high. DRAIN to PARKED once the output is low. PARKED to LOAD on a go edge. LOAD to RUN always. Any state returns to RUN when the enable is clear.

Top module: `clkout_phase_align`

## Requirements
- R1: During and directly after reset, hold_o, preload_o and late_half_o are all 0.
- R2: With align_en at 0, strobe edges change no output, and clearing align_en while the hold is asserted lowers hold_o at the next rising clk edge without a preload.
- R3: align_rise=1 makes the rising strobe edge the go edge and the falling edge the stop edge; align_rise=0 swaps the two.
- R4: A stop edge while running, with div_level at 0, raises hold_o on the third rising clk edge after the strobe transition. The transition must not fall inside the setup window of an edge.
- R5: A stop edge while running, with div_level at 1, leaves hold_o at 0 until div_level is seen at 0. hold_o then rises at the following rising clk edge.
- R6: A go edge while parked raises preload_o for exactly one cycle, on the third rising clk edge after the transition, with hold_o still 1. At the next edge both hold_o and preload_o are 0.
- R7: late_half_o equals 1 together with preload_o when the go transition came while clk was low (after a falling clk edge). It equals 0 when the transition came while clk was high. It is 0 whenever preload_o is 0.
- R8: A go edge while the output is running is ignored: hold_o and preload_o stay 0.
- R9: hold_o never rises in a cycle whose previous cycle saw div_level at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (the divider's source clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_in | input | 1 | Asynchronous alignment strobe |
| align_en | input | 1 | 1 enables the feature, 0 disables it |
| align_rise | input | 1 | 1: rising edge is go; 0: falling edge is go |
| div_level | input | 1 | Present level of the divided output clock |
| hold_o | output | 1 | Freeze request to the divider chain |
| preload_o | output | 1 | One-cycle zero-load of all divider stage counters |
| late_half_o | output | 1 | Go edge arrived in the low half of clk; valid with preload_o |

## Verification
The hardest situation to reach from the ports is telling the two half-cycle arrival cases apart. Both produce the same integer-cycle latency, and only the late flag differs. The stimulus therefore places each strobe transition either 1 ns after a rising clk edge or 1 ns before the next one. It does this on go edges under both polarities and checks the flag alongside the preload pulse. The drain path is reached by holding div_level high at the stop edge and lowering it in a later cycle.

// File: rtl/clkout_align_pkg.sv
package clkout_align_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_PARKED = 2'd2,
        ST_LOAD   = 2'd3
    } align_state_t;

    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/align_dual_sync.sv
module align_dual_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pos_q,
    output logic neg_q
);
    import clkout_align_pkg::*;

    localparam int DEPTH = (STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : STAGES;

    logic [DEPTH-1:0] pos_chain;
    logic [DEPTH-1:0] neg_chain;

    // rising-edge lane
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_chain <= '0;
        else        pos_chain <= {pos_chain[DEPTH-2:0], din};
    end

    // falling-edge lane: gives the half-period view of the strobe
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_chain <= '0;
        else        neg_chain <= {neg_chain[DEPTH-2:0], din};
    end

    assign pos_q = pos_chain[DEPTH-1];
    assign neg_q = neg_chain[DEPTH-1];

endmodule

// File: rtl/align_edge_detect.sv
module align_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_q,
    input  logic neg_q,
    input  logic rise_is_go,
    output logic go_edge,
    output logic stop_edge,
    output logic late_half
);
    logic pos_d;
    logic neg_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_d <= 1'b0;
            neg_s <= 1'b0;
        end else begin
            pos_d <= pos_q;
            neg_s <= neg_q;
        end
    end

    logic any_edge;
    assign any_edge  = pos_q ^ pos_d;
    assign go_edge   = any_edge & (pos_q == rise_is_go);
    assign stop_edge = any_edge & (pos_q != rise_is_go);
    // when the falling lane lags, the transition arrived in the low half of clk
    assign late_half = (neg_s != pos_q);

endmodule

// File: rtl/align_fsm.sv
module align_fsm
    import clkout_align_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic go_edge,
    input  logic stop_edge,
    input  logic late_half,
    input  logic div_level,
    output logic hold_o,
    output logic preload_o,
    output logic late_half_o
);
    align_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN:    if (stop_edge) nxt = div_level ? ST_DRAIN : ST_PARKED;
                ST_DRAIN:  if (!div_level) nxt = ST_PARKED;
                ST_PARKED: if (go_edge) nxt = ST_LOAD;
                ST_LOAD:   nxt = ST_RUN;
                default:   nxt = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_o      <= 1'b0;
            preload_o   <= 1'b0;
            late_half_o <= 1'b0;
        end else begin
            hold_o      <= (nxt == ST_PARKED) || (nxt == ST_LOAD);
            preload_o   <= (nxt == ST_LOAD);
            late_half_o <= (nxt == ST_LOAD) && late_half;
        end
    end

    // R9
    hold_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> !$past(div_level));
    // R6
    preload_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preload_o |=> (!preload_o && !hold_o));
    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!hold_o && !preload_o));
    // R7
    late_only_with_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        late_half_o |-> preload_o);
    // R6
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_o) |-> ($past(preload_o) || !$past(enable)));

endmodule

// File: rtl/clkout_phase_align.sv
module clkout_phase_align #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic align_in,
    input  logic align_en,
    input  logic align_rise,
    input  logic div_level,
    output logic hold_o,
    output logic preload_o,
    output logic late_half_o
);
    logic pos_q, neg_q;
    logic go_edge, stop_edge, late_half;

    align_dual_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (align_in),
        .pos_q (pos_q),
        .neg_q (neg_q)
    );

    align_edge_detect u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pos_q      (pos_q),
        .neg_q      (neg_q),
        .rise_is_go (align_rise),
        .go_edge    (go_edge),
        .stop_edge  (stop_edge),
        .late_half  (late_half)
    );

    align_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (align_en),
        .go_edge     (go_edge),
        .stop_edge   (stop_edge),
        .late_half   (late_half),
        .div_level   (div_level),
        .hold_o      (hold_o),
        .preload_o   (preload_o),
        .late_half_o (late_half_o)
    );

endmodule

// File: tb/tb_clkout_phase_align.sv
module tb_clkout_phase_align;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic align_in = 1'b0, align_en = 1'b0, align_rise = 1'b1, div_level = 1'b0;
    logic hold_o, preload_o, late_half_o;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    clkout_phase_align dut (
        .clk(clk), .rst_n(rst_n), .align_in(align_in), .align_en(align_en),
        .align_rise(align_rise), .div_level(div_level),
        .hold_o(hold_o), .preload_o(preload_o), .late_half_o(late_half_o)
    );

    // {en, rise, level, strobe, late_drive, exp_hold, exp_preload, exp_late}
    localparam int NV = 11;
    localparam logic [7:0] VEC [NV] = '{
        8'b1101_0000, // R8 go edge while running
        8'b1110_0000, // R5 stop edge with output high: drain
        8'b1100_0100, // R5 R9 output low: park
        8'b1101_0110, // R6 go edge: preload, early half
        8'b1100_0100, // R4 stop edge with output low
        8'b1101_1111, // R7 go edge in low half of clk
        8'b1000_0000, // R3 falling is go under rise=0: ignored while running
        8'b1001_0100, // R3 rising is stop under rise=0
        8'b1000_1111, // R3 R7 falling go edge, low half
        8'b0001_0000, // R2 disabled
        8'b0000_0000  // R2 disabled
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R8";
            1: return "R5";
            2: return "R9";
            3: return "R6";
            4: return "R4";
            5: return "R7";
            6, 7: return "R3";
            8: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act={hold,pre,late}=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic rise, input logic lvl,
                         input logic strobe, input logic late);
        @(posedge clk);
        if (late) #3; else #1;
        align_en = en; align_rise = rise; div_level = lvl; align_in = strobe;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #5;
        chk("R1 in reset", {hold_o, preload_o, late_half_o}, 3'b000);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 chk("R1 after reset", {hold_o, preload_o, late_half_o}, 3'b000);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] v;
            logic [2:0] post;
            v = VEC[i];
            drive(v[7], v[6], v[5], v[4], v[3]);
            repeat (3) @(posedge clk);
            #1 chk(vtag(i), {hold_o, preload_o, late_half_o}, v[2:0]);
            post = v[1] ? 3'b000 : {v[2], 2'b00};
            @(posedge clk);
            #1 chk(vtag(i), {hold_o, preload_o, late_half_o}, post);
        end

        // R4 exact latency of the stop edge
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        repeat (4) @(posedge clk);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        repeat (2) @(posedge clk);
        #1 chk("R4 not yet", {hold_o, preload_o, late_half_o}, 3'b000);
        @(posedge clk);
        #1 chk("R4 third edge", {hold_o, preload_o, late_half_o}, 3'b100);

        // R2 clearing enable while parked releases hold, no preload
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        @(posedge clk);
        #1 chk("R2 release", {hold_o, preload_o, late_half_o}, 3'b000);
        repeat (3) @(posedge clk);
        #1 chk("R2 stays", {hold_o, preload_o, late_half_o}, 3'b000);

        // R8 after re-enable, a go edge while running is ignored
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        repeat (3) @(posedge clk);
        #1 chk("R8 re-enabled", {hold_o, preload_o, late_half_o}, 3'b000);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule